// File: doc/BRIEF.md
# Reseed Source Selection Unit

This unit assembles the seed block handed to a random-number generator each time the generator must be reseeded. The seed block is 768 bits wide. Its lower half holds a 384-bit personalization value. Its upper half holds a 384-bit seed taken from one of four sources, picked by fixed priority:

- a software-written external seed;
- a 128-bit test seed that is shifted in one bit per write;
- a deterministic seed built from a forced value and a reseed counter;
- an entropy input port.

Software loads the personalization and external-seed words through a single word-write port. A request input, an accepted test bit, or an exhausted generation budget starts a reseed. The assembled block then appears on `seed_o` together with a one-cycle load strobe.

The unit also keeps the generation budget. Each reseed loads the budget, and each generation uses one unit of it. A generation requested when the budget is empty first forces a reseed. An accepted test bit causes a reseed and a generation in the same cycle. The generator itself is not part of this block.

Top module: `reseed_src_unit`

## Requirements
- R1: After `rst_ni` is released, `seed_o` is all zeros, `seed_load_o` and `regen_o` are low, and `budget_o` is 0. All word registers, the test seed and the forced counter clear to zero.
- R2: A write with `wr_pers_i`=0 stores `wr_data_i` in external-seed word `wr_idx_i`, for indices 0 to 11. Word k occupies seed-half bits [32k+31:32k]. A write to index 12 to 15 changes no word.
- R3: A write with `wr_pers_i`=1 stores personalization word `wr_idx_i`. Word k occupies `seed_o` bits [32k+31:32k]. When `pers_dis_i`=1 at the reseed, `seed_o[383:0]` is all zeros.
- R4: Seed-half source priority: the external seed when `ext_sel_i`=1; otherwise the test seed when `test_mode_i`=1; otherwise the forced seed when `forced_val_i` is nonzero; otherwise `entropy_i`.
- R5: An accepted test bit shifts the 128-bit test seed left by one and places `test_bit_i` at bit 0. In test-seed or forced-seed selection, the 128-bit value sits in `seed_o[511:384]`, and `seed_o[767:512]` is zero.
- R6: A test-bit write is accepted only if `test_mode_i`, `trss_en_i` and `osc_en_i` are all 1 and `soft_rst_i` is 0. Otherwise the write has no effect.
- R7: An accepted test bit causes a reseed, which uses the updated test seed, and a generation in the same cycle.
- R8: Each reseed that selects the forced seed increments a 64-bit counter first. The seed is then {`forced_val_i`, counter}, with the counter in the low 64 bits.
- R9: The entropy source places `entropy_i` unchanged in `seed_o[767:384]`.
- R10: A reseed loads `budget_o` with 2^BUDGET_W. A reseed combined with a generation in the same cycle leaves 2^BUDGET_W-1. A generation alone decrements the budget. A generation at budget 0 first performs an automatic reseed.
- R11: For a request sampled at a clock edge, `seed_o` and a single-cycle `seed_load_o` appear in the cycle after that edge. `regen_o` follows the same timing. Requests made while `soft_rst_i`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Word write enable |
| wr_pers_i | input | 1 | 1 selects personalization words, 0 selects external-seed words |
| wr_idx_i | input | 4 | Word index |
| wr_data_i | input | 32 | Word data |
| ext_sel_i | input | 1 | Select external seed |
| test_mode_i | input | 1 | Test mode |
| pers_dis_i | input | 1 | Personalization disable |
| trss_en_i | input | 1 | Entropy source enable |
| osc_en_i | input | 1 | Oscillator enable |
| soft_rst_i | input | 1 | Block held in reset |
| forced_val_i | input | 64 | Forced deterministic value, nonzero enables the forced source |
| entropy_i | input | 384 | Entropy input |
| reseed_req_i | input | 1 | Reseed request |
| gen_req_i | input | 1 | Generation request |
| test_bit_we_i | input | 1 | Test-bit write |
| test_bit_i | input | 1 | Test bit value |
| seed_o | output | 768 | Assembled seed block |
| seed_load_o | output | 1 | Seed load strobe |
| regen_o | output | 1 | Generation strobe |
| budget_o | output | 49 | Remaining generation budget |

## Verification
The bench builds the unit with BUDGET_W=3, so a full budget is 8 generations. This makes it possible to drain the budget completely and reach the automatic reseed within a few cycles. The other parameters keep their defaults. At those defaults, shifting all 128 test bits and sweeping all eight combinations of the three source selectors take only a few hundred cycles.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    SRC_EXT     = 2'd0,
    SRC_TEST    = 2'd1,
    SRC_FORCED  = 2'd2,
    SRC_ENTROPY = 2'd3
  } seed_src_e;
endpackage

// File: rtl/rsu_word_bank.sv
module rsu_word_bank #(
  parameter int NUM_WORDS = 12,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [WORD_W-1:0]           data_i,
  output logic [NUM_WORDS*WORD_W-1:0] words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 words_o[g*WORD_W +: WORD_W] <= '0;
      else if (we_i && idx_i == IDX_W'(g))         words_o[g*WORD_W +: WORD_W] <= data_i;
    end
  end

  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i >= IDX_W'(NUM_WORDS)) |=> $stable(words_o));
endmodule

// File: rtl/rsu_test_shift.sv
module rsu_test_shift #(
  parameter int TEST_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              bit_i,
  output logic [TEST_W-1:0] seed_nxt_o
);
  logic [TEST_W-1:0] ts_q;

  assign seed_nxt_o = acc_i ? {ts_q[TEST_W-2:0], bit_i} : ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ts_q <= '0;
    else if (acc_i) ts_q <= {ts_q[TEST_W-2:0], bit_i};
  end

  p_shift_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (ts_q[0] == $past(bit_i)) && (ts_q[TEST_W-1:1] == $past(ts_q[TEST_W-2:0])));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(ts_q));
endmodule

// File: rtl/rsu_seed_src.sv
module rsu_seed_src
  import rsu_pkg::*;
#(
  parameter int HALF_W  = 384,
  parameter int TEST_W  = 128,
  parameter int FORCE_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               ext_sel_i,
  input  logic               test_mode_i,
  input  logic [FORCE_W-1:0] forced_val_i,
  input  logic [HALF_W-1:0]  ext_words_i,
  input  logic [TEST_W-1:0]  test_seed_i,
  input  logic [HALF_W-1:0]  entropy_i,
  output seed_src_e          src_o,
  output logic [HALF_W-1:0]  half_o
);
  logic [FORCE_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (ext_sel_i)                 src_o = SRC_EXT;
    else if (test_mode_i)          src_o = SRC_TEST;
    else if (forced_val_i != '0)   src_o = SRC_FORCED;
    else                           src_o = SRC_ENTROPY;
  end

  assign cnt_nxt = cnt_q + FORCE_W'(1);

  always_comb begin
    unique case (src_o)
      SRC_EXT:    half_o = ext_words_i;
      SRC_TEST:   half_o = HALF_W'(test_seed_i);
      SRC_FORCED: half_o = HALF_W'({forced_val_i, cnt_nxt});
      default:    half_o = entropy_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (fire_i && src_o == SRC_FORCED)  cnt_q <= cnt_nxt;
  end

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && src_o == SRC_FORCED) |=> cnt_q == $past(cnt_q) + FORCE_W'(1));
  p_cnt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && src_o == SRC_FORCED) |=> $stable(cnt_q));
endmodule

// File: rtl/rsu_budget.sv
module rsu_budget #(
  parameter int BUDGET_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reseed_i,
  input  logic              regen_i,
  output logic [BUDGET_W:0] budget_o,
  output logic              empty_o
);
  localparam logic [BUDGET_W:0] FULL = {1'b1, {BUDGET_W{1'b0}}};

  assign empty_o = (budget_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       budget_o <= '0;
    else if (reseed_i) budget_o <= regen_i ? FULL - 1'b1 : FULL;
    else if (regen_i)  budget_o <= budget_o - 1'b1;
  end

  p_budget_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    budget_o <= FULL);
  p_budget_decr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regen_i && !reseed_i) |=> budget_o == $past(budget_o) - 1'b1);
endmodule

// File: rtl/reseed_src_unit.sv
module reseed_src_unit
  import rsu_pkg::*;
#(
  parameter int NUM_WORDS = 12,
  parameter int WORD_W    = 32,
  parameter int TEST_W    = 128,
  parameter int FORCE_W   = 64,
  parameter int BUDGET_W  = 48,
  localparam int HALF_W   = NUM_WORDS * WORD_W,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_pers_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic                ext_sel_i,
  input  logic                test_mode_i,
  input  logic                pers_dis_i,
  input  logic                trss_en_i,
  input  logic                osc_en_i,
  input  logic                soft_rst_i,
  input  logic [FORCE_W-1:0]  forced_val_i,
  input  logic [HALF_W-1:0]   entropy_i,
  input  logic                reseed_req_i,
  input  logic                gen_req_i,
  input  logic                test_bit_we_i,
  input  logic                test_bit_i,
  output logic [2*HALF_W-1:0] seed_o,
  output logic                seed_load_o,
  output logic                regen_o,
  output logic [BUDGET_W:0]   budget_o
);
  logic [HALF_W-1:0] ext_words, pers_words, half;
  logic [TEST_W-1:0] test_nxt;
  logic              tb_acc, regen, fire, empty;
  seed_src_e         src;

  assign tb_acc = test_bit_we_i && test_mode_i && trss_en_i && osc_en_i && !soft_rst_i;
  assign regen  = !soft_rst_i && (gen_req_i || tb_acc);
  // an exhausted budget forces a reseed ahead of the generation
  assign fire   = !soft_rst_i && (reseed_req_i || tb_acc || (gen_req_i && empty));

  rsu_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_ext_bank (
    .clk_i, .rst_ni, .we_i(wr_en_i && !wr_pers_i), .idx_i(wr_idx_i),
    .data_i(wr_data_i), .words_o(ext_words));

  rsu_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pers_bank (
    .clk_i, .rst_ni, .we_i(wr_en_i && wr_pers_i), .idx_i(wr_idx_i),
    .data_i(wr_data_i), .words_o(pers_words));

  rsu_test_shift #(.TEST_W(TEST_W)) u_test_shift (
    .clk_i, .rst_ni, .acc_i(tb_acc), .bit_i(test_bit_i), .seed_nxt_o(test_nxt));

  rsu_seed_src #(.HALF_W(HALF_W), .TEST_W(TEST_W), .FORCE_W(FORCE_W)) u_seed_src (
    .clk_i, .rst_ni, .fire_i(fire), .ext_sel_i, .test_mode_i, .forced_val_i,
    .ext_words_i(ext_words), .test_seed_i(test_nxt), .entropy_i,
    .src_o(src), .half_o(half));

  rsu_budget #(.BUDGET_W(BUDGET_W)) u_budget (
    .clk_i, .rst_ni, .reseed_i(fire), .regen_i(regen),
    .budget_o, .empty_o(empty));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_o      <= '0;
      seed_load_o <= 1'b0;
      regen_o     <= 1'b0;
    end else begin
      seed_load_o <= fire;
      regen_o     <= regen;
      if (fire) seed_o <= {half, pers_dis_i ? {HALF_W{1'b0}} : pers_words};
    end
  end

  p_load_after_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reseed_req_i && !soft_rst_i) |=> seed_load_o);
  p_quiet_in_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !seed_load_o && !regen_o);
  p_pers_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && pers_dis_i) |=> seed_o[HALF_W-1:0] == '0);
  p_narrow_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ext_sel_i && test_mode_i) |=> seed_o[2*HALF_W-1:HALF_W+TEST_W] == '0);
  p_testbit_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_acc |=> seed_load_o && regen_o);
  p_ext_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && ext_sel_i) |=> seed_o[2*HALF_W-1:HALF_W] == $past(ext_words));
endmodule

// File: tb/reseed_src_unit_tb.sv
module reseed_src_unit_tb;
  localparam int HW = 384;
  localparam int BW = 3;
  localparam logic [BW:0] FULL = 4'd8;

  logic clk = 0, rst_ni = 0;
  always #5 clk = ~clk;

  logic wr_en = 0, wr_pers = 0; logic [3:0] wr_idx = 0; logic [31:0] wr_data = 0;
  logic ext_sel = 0, test_mode = 0, pers_dis = 0, trss = 0, osc = 0, srst = 0;
  logic [63:0] forced = 0; logic [HW-1:0] entropy = 0;
  logic rs = 0, gen = 0, tbwe = 0, tbbit = 0;
  logic [2*HW-1:0] seed; logic load, regen; logic [BW:0] budget;

  reseed_src_unit #(.BUDGET_W(BW)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_pers_i(wr_pers), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .ext_sel_i(ext_sel), .test_mode_i(test_mode),
    .pers_dis_i(pers_dis), .trss_en_i(trss), .osc_en_i(osc), .soft_rst_i(srst),
    .forced_val_i(forced), .entropy_i(entropy), .reseed_req_i(rs), .gen_req_i(gen),
    .test_bit_we_i(tbwe), .test_bit_i(tbbit), .seed_o(seed), .seed_load_o(load),
    .regen_o(regen), .budget_o(budget));

  int errors = 0, checks = 0;
  logic [31:0] m_ext [12], m_pers [12];
  logic [127:0] m_ts = 0; logic [63:0] m_cnt = 0; logic [BW:0] m_bud = 0;
  logic [2*HW-1:0] m_seed = 0;

  task automatic chk(string tag, logic [2*HW-1:0] act, logic [2*HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic pers, logic [3:0] idx, logic [31:0] d);
    wr_en = 1; wr_pers = pers; wr_idx = idx; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
    if (idx < 12) begin if (pers) m_pers[idx] = d; else m_ext[idx] = d; end
  endtask

  // one cycle of requests, model update, then check at the ports
  task automatic step(string tag, logic r, logic g, logic tw, logic tb);
    logic acc, rg, f; logic [HW-1:0] half, ph;
    acc = tw && test_mode && trss && osc && !srst;
    if (acc) m_ts = {m_ts[126:0], tb};
    rg = !srst && (g || acc);
    f  = !srst && (r || acc || (g && m_bud == 0));
    if (f) begin
      if (ext_sel) for (int i = 0; i < 12; i++) half[i*32 +: 32] = m_ext[i];
      else if (test_mode) half = HW'(m_ts);
      else if (forced != 0) begin m_cnt++; half = HW'({forced, m_cnt}); end
      else half = entropy;
      for (int i = 0; i < 12; i++) ph[i*32 +: 32] = pers_dis ? 32'h0 : m_pers[i];
      m_seed = {half, ph};
      m_bud = rg ? FULL - 1 : FULL;
    end else if (rg) m_bud = m_bud - 1;
    rs = r; gen = g; tbwe = tw; tbbit = tb;
    @(posedge clk); #1;
    rs = 0; gen = 0; tbwe = 0; tbbit = 0;
    chk({tag, " load"}, 768'(load), 768'(f));
    chk({tag, " regen"}, 768'(regen), 768'(rg));
    chk({tag, " budget"}, 768'(budget), 768'(m_bud));
    chk({tag, " seed"}, seed, m_seed);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) begin m_ext[i] = 0; m_pers[i] = 0; end
    repeat (3) @(posedge clk); #1 rst_ni = 1; #1;
    // R1 reset state
    chk("R1 seed", seed, '0);
    chk("R1 load", 768'(load), 0);
    chk("R1 regen", 768'(regen), 0);
    chk("R1 budget", 768'(budget), 0);
    // R10 first generation at empty budget auto-reseeds (entropy source)
    entropy = {12{32'hC0DE_0001}};
    step("R10 auto first", 0, 1, 0, 0);
    // R2 R3 word writes, out-of-range ignored
    for (int i = 0; i < 12; i++) begin
      wr(0, 4'(i), 32'hE000_0000 + 32'(i) * 32'h0101_0101);
      wr(1, 4'(i), 32'hA500_0000 | 32'(i));
    end
    for (int i = 12; i < 16; i++) wr(0, 4'(i), 32'hDEAD_BEEF);
    ext_sel = 1;
    step("R2 ext", 1, 0, 0, 0);
    step("R11 single pulse", 0, 0, 0, 0);
    pers_dis = 1;
    step("R3 pers dis", 1, 0, 0, 0);
    pers_dis = 0;
    // R4 priority sweep over all selector combinations; R9 entropy
    for (int k = 0; k < 8; k++) begin
      ext_sel = k[2]; test_mode = k[1]; forced = k[0] ? 64'h1234_5678_9ABC_DEF0 : 64'h0;
      entropy = {12{32'h5A00_0000 | 32'(k)}};
      step("R4 R9 prio", 1, 0, 0, 0);
    end
    // R5 R7 full 128-bit test seed shift
    ext_sel = 0; test_mode = 1; trss = 1; osc = 1; forced = 0;
    for (int i = 0; i < 128; i++) step("R5 R7 shift", 0, 0, 1, 1'((i % 3 == 0) ^ i[4]));
    // R6 gating: each missing condition blocks the write
    trss = 0; step("R6 no trss", 0, 0, 1, 1); trss = 1;
    osc = 0;  step("R6 no osc", 0, 0, 1, 1);  osc = 1;
    srst = 1; step("R6 R11 in rst", 1, 1, 1, 1); srst = 0;
    test_mode = 0; step("R6 no test", 0, 0, 1, 1); test_mode = 1;
    step("R6 ts unchanged", 1, 0, 0, 0);
    // R8 forced counter
    test_mode = 0; forced = 64'hFEED_0000_0000_0001;
    for (int i = 0; i < 3; i++) step("R8 forced", 1, 0, 0, 0);
    // R10 budget drain and automatic reseed
    forced = 0; entropy = {12{32'h0BAD_CAFE}};
    step("R10 reseed", 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R10 drain", 0, 1, 0, 0);
    entropy = {12{32'h1357_9BDF}};
    step("R10 auto", 0, 1, 0, 0);
    step("R10 reseed+gen", 1, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule